// File: doc/BRIEF.md
# I2C Target Bus-Event Interrupt Controller

This block listens to an I2C bus as a target with a fixed 7-bit address. SCL and SDA arrive already sampled into the system clock domain. It finds START and STOP conditions and SCL edges, and follows each byte through its acknowledge slot. Each event it sees sets a sticky flag in a 16-bit status register. A companion enable register selects which of these flags drive a single interrupt line.

When the block's own address arrives with the write direction, the first data byte that follows is latched into an 8-bit memory pointer, and a dedicated flag marks the capture. A second flag fires early in every transfer, once two SCL clocks have followed a START. This gives software a head start before the address byte is complete. In the read direction the block returns a fixed holding byte and flags each byte whose acknowledge slot has been sampled.

Software uses a simple register port with combinational read data. The status register is at offset 0, the enable register at offset 1 and the pointer at offset 2.

Top module: `i2c_tgt_evt_irq`

## Requirements
- R1: After reset, the status, enable and pointer registers read 0, `irq` is 0 and `sda_oe` is 0.
- R2: A rise of SDA while SCL is high (STOP) sets status bit 5.
- R3: A START (fall of SDA while SCL is high) followed by two SCL rising edges sets status bit 4, once per START.
- R4: On an address byte (7 address bits MSB first, then a direction bit with 0 meaning write) equal to `OWN_ADDR`, the block drives `sda_oe` high through the acknowledge clock. On any other address it never drives SDA, and it captures nothing until the next START.
- R5: After an address match with a write, every received byte is acknowledged. Only the first byte is copied into the pointer (offset 2, bits 7:0), and that copy sets status bit 3.
- R6: After an address match with a read, the block shifts out `TX_BYTE` MSB first, once per byte. Status bit 1 is set when the acknowledge slot after the byte has been sampled, whether it holds an ACK or a NACK. After a NACK the block releases the bus until the next START.
- R7: Status flags are sticky. Only a software write clears them. A write to offset 0 loads bits 5, 4, 3 and 1 from the write data, so writing 1 sets a flag and writing 0 clears it.
- R8: Status bits 15:6, 2 and 0 always read 0. In the enable register only bits 5:3 are writable, and all its other bits read 0.
- R9: `irq` is high whenever any status flag is set together with its enable bit, using the same bit position. Status bit 1 raises `irq` regardless of the enable register.
- R10: If a hardware event sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R11: A repeated START restarts the SCL count and the byte tracking. The first write byte after the next address match is captured as a new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| sda_oe | output | 1 | Pulls SDA low when high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 status, 1 enable, 2 pointer |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bus side is exercised with five patterns:
- a matching write of two bytes;
- a write to a foreign address;
- a matching read of two bytes ending in ACK then NACK;
- a repeated START between two matching writes;
- a START followed directly by a STOP.

The foreign-address case tells real address decoding apart from acknowledging every byte. The two-byte write separates capturing only the first byte from capturing every byte. The repeated START shows whether the pointer capture re-arms. The START/STOP pair, timed against a software clear, shows which side wins a collision on the same flag.

On the register side, the bench writes all ones and then all zeros. This tells the writable flag bits apart from the reserved bits, and shows that transmit-complete raises `irq` with every enable cleared.

// File: rtl/i2c_evt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the I2C target event block.
// Assumes the 16-bit register layout given in the brief.
package i2c_evt_pkg;
    localparam int FLAG_STOP = 5;
    localparam int FLAG_SAD  = 4;
    localparam int FLAG_MAD  = 3;
    localparam int FLAG_TXC  = 1;
    localparam int REG_W     = 16;

    localparam logic [REG_W-1:0] STAT_MASK = 16'h003A;
    localparam logic [REG_W-1:0] EN_MASK   = 16'h0038;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;
endpackage

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
// Module: i2c_bus_cond
// Decodes START, STOP and SCL edges from the sampled bus lines.
// Assumes scl_i/sda_i are already synchronous to clk. The events are
// combinational against the previous sample, so they are valid in the
// cycle in which a change is first seen.
module i2c_bus_cond
    import i2c_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    // Hold the previous bus sample (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify the transition between the previous and current sample.
    always_comb begin
        evt.start = scl_q & scl_i & sda_q & ~sda_i;
        evt.stop  = scl_q & scl_i & ~sda_q & sda_i;
        evt.rise  = ~scl_q & scl_i;
        evt.fall  = scl_q & ~scl_i;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
// Module: i2c_tgt_fsm
// Follows the target side of a transfer: address decode, acknowledge,
// write-byte reception with first-byte pointer capture, and read-byte
// transmission of a fixed holding byte. Emits one-cycle event pulses.
// Assumes SDA is only changed by the controller while SCL is low.
module i2c_tgt_fsm
    import i2c_evt_pkg::*;
#(
    parameter int         ADDR_W   = 7,
    parameter logic [6:0] OWN_ADDR = 7'h50,
    parameter logic [7:0] TX_BYTE  = 8'hA5,
    parameter int         SAD_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_evt_t   evt,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       stop_hit,
    output logic       sad_hit,
    output logic       mad_hit,
    output logic       txc_hit,
    output logic [7:0] ptr_data
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CW     = $clog2(SAD_CLKS + 1);
    localparam int BW     = $clog2(BYTE_W + 1);

    tgt_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [BW-1:0]     bit_cnt;
    logic [CW-1:0]     clk_cnt;
    logic              armed;
    logic              first;
    logic              rnw;
    logic [7:0]        tx_sh;

    // Select the outgoing bit for the current bit position.
    always_comb tx_sh = TX_BYTE << bit_cnt;

    assign ptr_data = shreg;

    // Advance the transfer on each bus event; START and STOP take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            clk_cnt  <= '0;
            armed    <= 1'b0;
            first    <= 1'b0;
            rnw      <= 1'b0;
            sda_oe   <= 1'b0;
            stop_hit <= 1'b0;
            sad_hit  <= 1'b0;
            mad_hit  <= 1'b0;
            txc_hit  <= 1'b0;
        end else begin
            stop_hit <= 1'b0;
            sad_hit  <= 1'b0;
            mad_hit  <= 1'b0;
            txc_hit  <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                clk_cnt <= '0;
                armed   <= 1'b1;
                first   <= 1'b1;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                armed    <= 1'b0;
                sda_oe   <= 1'b0;
                stop_hit <= 1'b1;
            end else if (evt.rise) begin
                if (armed) begin
                    if (clk_cnt == CW'(SAD_CLKS - 1)) begin
                        sad_hit <= 1'b1;
                        armed   <= 1'b0;
                    end
                    clk_cnt <= clk_cnt + 1'b1;
                end
                case (state)
                    ST_ADDR, ST_WDAT: begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_RDAT: bit_cnt <= bit_cnt + 1'b1;
                    ST_RACK: begin
                        txc_hit <= 1'b1;
                        bit_cnt <= '0;
                        state   <= sda_i ? ST_SKIP : ST_RDAT;
                    end
                    default: ;
                endcase
            end else if (evt.fall) begin
                case (state)
                    ST_ADDR: if (bit_cnt == BW'(BYTE_W)) begin
                        if (shreg[BYTE_W-1:1] == OWN_ADDR) begin
                            state  <= ST_AACK;
                            rnw    <= shreg[0];
                            sda_oe <= 1'b1;
                        end else begin
                            state  <= ST_SKIP;
                        end
                    end
                    ST_AACK: begin
                        bit_cnt <= '0;
                        state   <= rnw ? ST_RDAT : ST_WDAT;
                        sda_oe  <= rnw ? ~TX_BYTE[7] : 1'b0;
                    end
                    ST_WDAT: if (bit_cnt == BW'(BYTE_W)) begin
                        state  <= ST_WACK;
                        sda_oe <= 1'b1;
                        if (first) begin
                            mad_hit <= 1'b1;
                            first   <= 1'b0;
                        end
                    end
                    ST_WACK: begin
                        state   <= ST_WDAT;
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                    end
                    ST_RDAT: if (bit_cnt == BW'(BYTE_W)) begin
                        state  <= ST_RACK;
                        sda_oe <= 1'b0;
                    end else begin
                        sda_oe <= ~tx_sh[7];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_evt_regs.sv
`timescale 1ns/1ps
// Module: i2c_evt_regs
// Holds the sticky status flags, the enable mask and the memory pointer,
// serves register reads and forms the interrupt. A hardware set wins over
// a software clear of the same flag in the same cycle.
module i2c_evt_regs
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_hit,
    input  logic             sad_hit,
    input  logic             mad_hit,
    input  logic             txc_hit,
    input  logic [7:0]       ptr_data,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic             irq
);
    logic [REG_W-1:0] hw_set;
    logic [REG_W-1:0] irq_mask;
    logic [7:0]       ptr_q;

    // Place the event pulses at their flag positions.
    always_comb begin
        hw_set            = '0;
        hw_set[FLAG_STOP] = stop_hit;
        hw_set[FLAG_SAD]  = sad_hit;
        hw_set[FLAG_MAD]  = mad_hit;
        hw_set[FLAG_TXC]  = txc_hit;
    end

    // Update flags, enables and pointer; hardware sets are OR'd last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            enable_o <= '0;
            ptr_q    <= '0;
        end else begin
            status_o <= ((reg_wr && reg_addr == 2'd0) ? (reg_wdata & STAT_MASK) : status_o) | hw_set;
            if (reg_wr && reg_addr == 2'd1) enable_o <= reg_wdata & EN_MASK;
            if (mad_hit) ptr_q <= ptr_data;
        end
    end

    // Return the addressed register.
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = status_o;
            2'd1:    reg_rdata = enable_o;
            2'd2:    reg_rdata = {8'h00, ptr_q};
            default: reg_rdata = '0;
        endcase
    end

    // Transmit-complete has no enable bit and always counts.
    always_comb begin
        irq_mask           = enable_o;
        irq_mask[FLAG_TXC] = 1'b1;
        irq                = |(status_o & irq_mask);
    end
endmodule

// File: rtl/i2c_tgt_evt_irq.sv
`timescale 1ns/1ps
// Module: i2c_tgt_evt_irq (top)
// I2C target that turns bus events into sticky, maskable interrupt flags
// and captures the first written byte as a memory pointer.
// Assumes synchronized bus inputs and an external open-drain SDA driver.
module i2c_tgt_evt_irq #(
    parameter logic [6:0] OWN_ADDR = 7'h50,
    parameter logic [7:0] TX_BYTE  = 8'hA5,
    parameter int         SAD_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    import i2c_evt_pkg::*;

    bus_evt_t   evt;
    logic       stop_hit;
    logic       sad_hit;
    logic       mad_hit;
    logic       txc_hit;
    logic [7:0] ptr_data;
    logic [15:0] status_w;
    logic [15:0] enable_w;

    i2c_bus_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_tgt_fsm #(
        .ADDR_W   (7),
        .OWN_ADDR (OWN_ADDR),
        .TX_BYTE  (TX_BYTE),
        .SAD_CLKS (SAD_CLKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .sda_i    (sda_i),
        .sda_oe   (sda_oe),
        .stop_hit (stop_hit),
        .sad_hit  (sad_hit),
        .mad_hit  (mad_hit),
        .txc_hit  (txc_hit),
        .ptr_data (ptr_data)
    );

    i2c_evt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_hit  (stop_hit),
        .sad_hit   (sad_hit),
        .mad_hit   (mad_hit),
        .txc_hit   (txc_hit),
        .ptr_data  (ptr_data),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status_o  (status_w),
        .enable_o  (enable_w),
        .irq       (irq)
    );
endmodule

// File: rtl/i2c_tgt_evt_chk.sv
`timescale 1ns/1ps
// Module: i2c_tgt_evt_chk
// Property checker bound to the top module. Watches ports and the
// register outputs of the flag block.
module i2c_tgt_evt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_i,
    input logic        sda_oe,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        irq,
    input logic [15:0] status,
    input logic [15:0] enable
);
    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~16'h003A) == 16'h0000) && ((enable & ~16'h0038) == 16'h0000));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr && reg_addr == 2'd0) |-> ((status & $past(status)) == $past(status)));

    // R9
    txc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> irq);

    // R9
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == 16'h0000 && !status[1]) |-> !irq);

    // R2
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |-> ##2 status[5]);

    // R4
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_i) || !sda_oe);
endmodule

bind i2c_tgt_evt_irq i2c_tgt_evt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .irq      (irq),
    .status   (status_w),
    .enable   (enable_w)
);

// File: tb/test_i2c_tgt_evt_irq.sv
`timescale 1ns/1ps
// Bench: drives an I2C controller model and the register port, and runs a
// behavioural reference that is compared with the outputs on every clock.
module test_i2c_tgt_evt_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mscl = 1'b1;
    logic        msda = 1'b1;
    logic        sda_oe;
    logic        sda_bus;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int H = 3;
    localparam logic [6:0] ME = 7'h50;
    localparam logic [7:0] HOLD = 8'hA5;

    always #5 clk = ~clk;

    assign sda_bus = msda & ~sda_oe;

    i2c_tgt_evt_irq i_i2c_tgt_evt_irq (
        .clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // ---------------- reference model ----------------
    localparam int M_IDLE = 0, M_ADDR = 1, M_AACK = 2, M_WDAT = 3,
                   M_WACK = 4, M_RDAT = 5, M_RACK = 6, M_SKIP = 7;
    logic [15:0] m_status = 0, m_en = 0;
    logic [7:0]  m_ptr = 0;
    bit   m_oe = 0;
    int   m_state = M_IDLE, m_bits = 0, m_clks = 0;
    bit   m_armed = 0, m_first = 0, m_read = 0;
    logic [7:0] m_sh = 0;
    bit   p_stop = 0, p_sad = 0, p_mad = 0, p_txc = 0;
    bit   last_scl = 1, last_sda = 1;

    function automatic logic [15:0] model_rd(input logic [1:0] a);
        if (a == 2'd0) return m_status;
        if (a == 2'd1) return m_en;
        if (a == 2'd2) return {8'h00, m_ptr};
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        bit bscl, bsda;
        if (!rst_n) begin
            m_status = 0; m_en = 0; m_ptr = 0; m_oe = 0; m_state = M_IDLE;
            m_bits = 0; m_clks = 0; m_armed = 0; m_first = 0; m_read = 0; m_sh = 0;
            p_stop = 0; p_sad = 0; p_mad = 0; p_txc = 0; last_scl = 1; last_sda = 1;
        end else begin
            bscl = mscl;
            bsda = msda & ~m_oe;
            if (reg_wr && reg_addr == 2'd0) m_status = reg_wdata & 16'h003A;
            if (p_stop) m_status[5] = 1;
            if (p_sad)  m_status[4] = 1;
            if (p_mad)  begin m_status[3] = 1; m_ptr = m_sh; end
            if (p_txc)  m_status[1] = 1;
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata & 16'h0038;
            p_stop = 0; p_sad = 0; p_mad = 0; p_txc = 0;
            if (last_scl && bscl && last_sda && !bsda) begin
                m_state = M_ADDR; m_bits = 0; m_clks = 0; m_armed = 1; m_first = 1; m_oe = 0;
            end else if (last_scl && bscl && !last_sda && bsda) begin
                m_state = M_IDLE; m_armed = 0; m_oe = 0; p_stop = 1;
            end else if (!last_scl && bscl) begin
                if (m_armed) begin
                    m_clks++;
                    if (m_clks == 2) begin p_sad = 1; m_armed = 0; end
                end
                if (m_state == M_ADDR || m_state == M_WDAT) begin
                    m_sh = {m_sh[6:0], bsda}; m_bits++;
                end else if (m_state == M_RDAT) m_bits++;
                else if (m_state == M_RACK) begin
                    p_txc = 1; m_bits = 0;
                    m_state = bsda ? M_SKIP : M_RDAT;
                end
            end else if (last_scl && !bscl) begin
                case (m_state)
                    M_ADDR: if (m_bits == 8) begin
                        if (m_sh[7:1] == ME) begin m_state = M_AACK; m_read = m_sh[0]; m_oe = 1; end
                        else m_state = M_SKIP;
                    end
                    M_AACK: begin
                        m_bits = 0;
                        if (m_read) begin m_state = M_RDAT; m_oe = !HOLD[7]; end
                        else begin m_state = M_WDAT; m_oe = 0; end
                    end
                    M_WDAT: if (m_bits == 8) begin
                        m_state = M_WACK; m_oe = 1;
                        if (m_first) begin p_mad = 1; m_first = 0; end
                    end
                    M_WACK: begin m_state = M_WDAT; m_bits = 0; m_oe = 0; end
                    M_RDAT: if (m_bits == 8) begin m_state = M_RACK; m_oe = 0; end
                            else m_oe = !HOLD[7 - m_bits];
                    default: ;
                endcase
            end
            last_scl = bscl;
            last_sda = bsda;
        end
    end

    // Per-clock comparison against the model (R9 irq, R4 SDA drive, R7 register view).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] exp_rd;
            exp_rd = model_rd(reg_addr);
            checks++;
            if (irq !== |(m_status & (m_en | 16'h0002))) begin
                errors++; $display("FAIL R9 irq actual %0b expected %0b", irq, |(m_status & (m_en | 16'h0002)));
            end
            checks++;
            if (sda_oe !== m_oe) begin
                errors++; $display("FAIL R4 sda_oe actual %0b expected %0b", sda_oe, m_oe);
            end
            checks++;
            if (reg_rdata !== exp_rd) begin
                errors++; $display("FAIL R7 rdata[%0d] actual %h expected %h", reg_addr, reg_rdata, exp_rd);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(); @(posedge clk); #2; endtask
    task automatic hold(input int n); repeat (n) tick(); endtask

    task automatic expect_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++; $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic bus_start();
        msda = 1; mscl = 1; hold(H);
        msda = 0; hold(H);
        mscl = 0; hold(H);
    endtask

    task automatic bus_rstart();
        msda = 1; hold(H);
        mscl = 1; hold(H);
        msda = 0; hold(H);
        mscl = 0; hold(H);
    endtask

    task automatic bus_stop();
        msda = 0; hold(H);
        mscl = 1; hold(H);
        msda = 1; hold(H);
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        msda = b; hold(H);
        mscl = 1; hold(1); seen = sda_bus; hold(H - 1);
        mscl = 0; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
        clk_bit(nack, s);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [15:0] rd;
        logic [7:0]  rb;
        bit ak;
        hold(4);
        rst_n = 1'b1;
        hold(2);
        // R1 reset state
        reg_read(2'd0, rd); expect_val("R1 status", rd, 16'h0000);
        reg_read(2'd1, rd); expect_val("R1 enable", rd, 16'h0000);
        reg_read(2'd2, rd); expect_val("R1 pointer", rd, 16'h0000);
        expect_val("R1 irq", {15'd0, irq}, 16'h0000);
        expect_val("R1 sda_oe", {15'd0, sda_oe}, 16'h0000);

        // R8 enable reserved bits
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, rd); expect_val("R8 enable mask", rd, 16'h0038);

        // R3 R5 R2 matching write of two bytes
        bus_start();
        hold(1);
        send_byte({ME, 1'b0}, ak); expect_val("R4 address ack", {15'd0, ak}, 16'h0001);
        reg_read(2'd0, rd); expect_val("R3 early flag", rd & 16'h0010, 16'h0010);
        send_byte(8'h3C, ak); expect_val("R5 first byte ack", {15'd0, ak}, 16'h0001);
        send_byte(8'h77, ak); expect_val("R5 second byte ack", {15'd0, ak}, 16'h0001);
        bus_stop(); hold(2);
        reg_read(2'd2, rd); expect_val("R5 pointer first byte", rd, 16'h003C);
        reg_read(2'd0, rd); expect_val("R2 R3 R5 flags", rd, 16'h0038);

        // R7 clear, set, reserved
        reg_write(2'd0, 16'h0000);
        reg_read(2'd0, rd); expect_val("R7 clear", rd, 16'h0000);
        reg_write(2'd0, 16'hFFFF);
        reg_read(2'd0, rd); expect_val("R7 R8 set all", rd, 16'h003A);
        hold(3);
        reg_read(2'd0, rd); expect_val("R7 sticky", rd, 16'h003A);
        reg_write(2'd0, 16'h0000);

        // R4 foreign address ignored
        bus_start();
        send_byte(8'h46, ak); expect_val("R4 foreign no ack", {15'd0, ak}, 16'h0000);
        send_byte(8'h11, ak); expect_val("R4 ignored byte no ack", {15'd0, ak}, 16'h0000);
        bus_stop(); hold(2);
        reg_read(2'd2, rd); expect_val("R4 pointer unchanged", rd, 16'h003C);
        reg_read(2'd0, rd); expect_val("R4 no capture flag", rd, 16'h0030);
        reg_write(2'd0, 16'h0000);

        // R6 R9 read with enables off
        reg_write(2'd1, 16'h0000);
        bus_start();
        send_byte({ME, 1'b1}, ak); expect_val("R6 read address ack", {15'd0, ak}, 16'h0001);
        recv_byte(1'b0, rb); expect_val("R6 first read byte", {8'h00, rb}, {8'h00, HOLD});
        recv_byte(1'b1, rb); expect_val("R6 second read byte", {8'h00, rb}, {8'h00, HOLD});
        bus_stop(); hold(2);
        reg_read(2'd0, rd); expect_val("R6 transmit flag", rd, 16'h0032);
        expect_val("R9 irq from transmit flag", {15'd0, irq}, 16'h0001);
        reg_write(2'd0, 16'h0030); hold(1);
        expect_val("R9 masked irq", {15'd0, irq}, 16'h0000);
        reg_write(2'd1, 16'h0020); hold(1);
        expect_val("R9 enabled irq", {15'd0, irq}, 16'h0001);
        reg_write(2'd0, 16'h0000);

        // R11 repeated start
        bus_start();
        send_byte({ME, 1'b0}, ak);
        send_byte(8'h12, ak);
        bus_rstart();
        send_byte({ME, 1'b0}, ak); expect_val("R11 re-address ack", {15'd0, ak}, 16'h0001);
        send_byte(8'h9A, ak);
        bus_stop(); hold(2);
        reg_read(2'd2, rd); expect_val("R11 new pointer", rd, 16'h009A);

        // R10 hardware set beats software clear
        reg_write(2'd0, 16'h0020);
        msda = 1; mscl = 1; hold(H);
        msda = 0; hold(H);
        msda = 1; tick();
        reg_write(2'd0, 16'h0000);
        hold(1);
        reg_read(2'd0, rd); expect_val("R10 collision", rd & 16'h0020, 16'h0020);
        hold(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule